// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sequences reset and reduced-power modes for a small 8-bit microcontroller core. It runs on the raw oscillator clock and is built to tolerate any duty cycle on it. A divide-by-two phase register produces the internal clock enables. The external reset pin first passes through a two-flop synchroniser. The pin then counts as a reset only after it has stayed high for two machine cycles of twelve oscillator periods each.

Software requests a low-power state by writing a power-control register. Idle stops only the CPU clock enable and leaves the peripheral enable running. Any enabled interrupt request or a hardware reset ends idle. Power-down drops every clock enable and asks the oscillator to stop. Only a hardware reset ends power-down. Both request bits clear when the controller returns to normal run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `core_rst` rises only after the synchronised reset pin has been high for 24 consecutive oscillator periods. With the two synchroniser stages added, the first edge with `core_rst` high is the 26th rising edge after `rst_pin` is first sampled high.
- R2: A `rst_pin` pulse shorter than the qualification window produces no `core_rst`. The count restarts from zero whenever the pin falls.
- R3: `core_rst` is high while `por_n` is low. It falls within three edges of `rst_pin` going low.
- R4: In run mode `cpu_clk_en` and `per_clk_en` are high on alternate oscillator cycles, that is, half of all cycles.
- R5: Writing `pcon_wdata` with bit 0 set and bit 1 clear enters idle. `cpu_clk_en` then stays low, `per_clk_en` keeps toggling, `osc_run` stays high, and `pcon_bits` reads 2'b01.
- R6: In idle, any bit of `irq_req` high for one cycle returns the block to run. `pcon_bits` clears to 2'b00.
- R7: A qualified reset in idle returns the block to run and clears `pcon_bits`.
- R8: Writing bit 1 (power-down) enters power-down. This holds even when bit 0 is also set, and `pcon_bits` then reads 2'b11. In power-down, `cpu_clk_en`, `per_clk_en` and `osc_run` are all low.
- R9: Interrupt requests have no effect in power-down.
- R10: In power-down, `osc_run` goes high as soon as the synchronised reset pin is high. A qualified reset then returns the block to run with `pcon_bits` cleared.
- R11: Register writes are ignored while the block is outside run mode or while `core_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, any duty cycle |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | PCON_W (8) | Write data: bit 0 idle request, bit 1 power-down request |
| irq_req | input | N_IRQ (4) | Enabled interrupt requests |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| core_rst | output | 1 | Synchronous core reset |
| pcon_bits | output | 2 | Current mode request bits {power-down, idle} |

## Verification
The assertions are checked on every cycle. They cover these properties:
- The reset count must reach its limit before `core_rst` rises.
- A low synchronised pin always clears the qualified reset.
- The clock enable pulses never last two cycles.
- Power-down holds until a reset.
- Idle always leaves on an interrupt.
- A write with bit 1 set always lands in power-down.
- The request bits stay put outside run mode.

The bench scenarios are the only place where whole sequences show up. These are the exact edge on which a long pin pulse becomes a reset, a 20-cycle pulse being dropped, the roughly fifty-percent duty of the enables, and mode entry and exit as seen at the ports.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_mode_e;

    localparam int REQ_IDLE_BIT = 0;
    localparam int REQ_DOWN_BIT = 1;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    assign sh_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int OSC_PER_MC = 12,
    parameter int MC_COUNT   = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_sync_i,
    output logic qual_o
);
    localparam int QUAL = OSC_PER_MC * MC_COUNT;
    localparam int CW   = $clog2(QUAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } qual_st_t;

    qual_st_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (!pin_sync_i) begin
            n_d.cnt  = '0;
            n_d.qual = 1'b0;
        end else begin
            if (n_q.cnt != CW'(QUAL)) n_d.cnt = n_q.cnt + 1'b1;
            n_d.qual = n_q.qual || (n_q.cnt == CW'(QUAL - 1));
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            n_q.cnt  <= '0;
            n_q.qual <= 1'b1;
        end else begin
            n_q <= n_d;
        end
    end

    assign qual_o = n_q.qual;

    p_full_count_r1: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(n_q.qual) |-> ($past(n_q.cnt) == CW'(QUAL - 1)));

    p_low_drops_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !pin_sync_i |=> !n_q.qual);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int PCON_W = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              core_rst_i,
    input  logic              wake_i,
    input  logic              we_i,
    input  logic [PCON_W-1:0] wdata_i,
    output pm_mode_e          mode_o,
    output logic [1:0]        bits_o
);
    typedef struct packed {
        pm_mode_e   mode;
        logic [1:0] bits;
    } fsm_st_t;

    fsm_st_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (core_rst_i) begin
            n_d.mode = PM_RUN;
            n_d.bits = 2'b00;
        end else begin
            unique case (n_q.mode)
                PM_RUN: begin
                    if (we_i) begin
                        n_d.bits = {wdata_i[REQ_DOWN_BIT], wdata_i[REQ_IDLE_BIT]};
                        if (wdata_i[REQ_DOWN_BIT])      n_d.mode = PM_DOWN;
                        else if (wdata_i[REQ_IDLE_BIT]) n_d.mode = PM_IDLE;
                    end
                end
                PM_IDLE: begin
                    if (wake_i) begin
                        n_d.mode = PM_RUN;
                        n_d.bits = 2'b00;
                    end
                end
                PM_DOWN: ;
                default: begin
                    n_d.mode = PM_RUN;
                    n_d.bits = 2'b00;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            n_q.mode <= PM_RUN;
            n_q.bits <= 2'b00;
        end else begin
            n_q <= n_d;
        end
    end

    assign mode_o = n_q.mode;
    assign bits_o = n_q.bits;

    p_idle_wake_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (n_q.mode == PM_IDLE && wake_i && !core_rst_i)
            |=> (n_q.mode == PM_RUN && n_q.bits == 2'b00));

    p_reset_exit_r7: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst_i |=> (n_q.mode == PM_RUN && n_q.bits == 2'b00));

    p_down_prio_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (n_q.mode == PM_RUN && !core_rst_i && we_i && wdata_i[REQ_DOWN_BIT])
            |=> (n_q.mode == PM_DOWN));

    p_down_hold_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (n_q.mode == PM_DOWN && !core_rst_i) |=> (n_q.mode == PM_DOWN));

    p_no_write_r11: assert property (@(posedge clk) disable iff (!arst_n)
        (n_q.mode != PM_RUN && !core_rst_i && !wake_i) |=> $stable(n_q.bits));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int OSC_PER_MC  = 12,
    parameter int MC_COUNT    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int N_IRQ       = 4,
    parameter int PCON_W      = 8
) (
    input  logic              osc_clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic [N_IRQ-1:0]  irq_req,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_run,
    output logic              core_rst,
    output logic [1:0]        pcon_bits
);
    logic     pin_s;
    logic     qual;
    pm_mode_e mode;

    typedef struct packed {
        logic ph;
    } div_st_t;

    div_st_t dv_d, dv_q;

    pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (osc_clk),
        .arst_n (por_n),
        .din    (rst_pin),
        .dout   (pin_s)
    );

    pmc_rst_qual #(.OSC_PER_MC(OSC_PER_MC), .MC_COUNT(MC_COUNT)) u_qual (
        .clk        (osc_clk),
        .arst_n     (por_n),
        .pin_sync_i (pin_s),
        .qual_o     (qual)
    );

    pmc_mode_fsm #(.PCON_W(PCON_W)) u_fsm (
        .clk        (osc_clk),
        .arst_n     (por_n),
        .core_rst_i (qual),
        .wake_i     (|irq_req),
        .we_i       (pcon_we),
        .wdata_i    (pcon_wdata),
        .mode_o     (mode),
        .bits_o     (pcon_bits)
    );

    always_comb begin
        dv_d    = dv_q;
        dv_d.ph = ~dv_q.ph;
    end

    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n) dv_q.ph <= 1'b0;
        else        dv_q    <= dv_d;
    end

    assign cpu_clk_en = dv_q.ph && (mode == PM_RUN);
    assign per_clk_en = dv_q.ph && (mode != PM_DOWN);
    assign osc_run    = (mode != PM_DOWN) || pin_s;
    assign core_rst   = qual;

    p_half_rate_r4: assert property (@(posedge osc_clk) disable iff (!por_n)
        per_clk_en |=> !per_clk_en);

    p_cpu_half_rate_r4: assert property (@(posedge osc_clk) disable iff (!por_n)
        cpu_clk_en |=> !cpu_clk_en);

    p_down_quiet_r8: assert property (@(posedge osc_clk) disable iff (!por_n)
        !osc_run |-> (!cpu_clk_en && !per_clk_en));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    logic       osc_clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = '0;
    logic [3:0] irq_req = '0;
    logic       cpu_clk_en, per_clk_en, osc_run, core_rst;
    logic [1:0] pcon_bits;

    always #5 osc_clk = ~osc_clk;

    pwr_mode_ctrl u0 (
        .osc_clk    (osc_clk),
        .por_n      (por_n),
        .rst_pin    (rst_pin),
        .pcon_we    (pcon_we),
        .pcon_wdata (pcon_wdata),
        .irq_req    (irq_req),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_run    (osc_run),
        .core_rst   (core_rst),
        .pcon_bits  (pcon_bits)
    );

    typedef struct {
        string req;
        int    field;
        int    exp;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    hi_cnt = 0;
    logic  cpu_last = 1'b0;
    logic  per_last = 1'b0;
    bit    done = 0;

    localparam int F_RST = 0, F_OSC = 1, F_PER = 2, F_CPU = 3, F_BITS = 4, F_CNT = 5;

    task automatic expect_f(input string r, input int f, input int e);
        item_t it;
        it.req = r; it.field = f; it.exp = e;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic pwrite(input logic [7:0] v);
        pcon_we = 1'b1; pcon_wdata = v;
        tick(1);
        pcon_we = 1'b0; pcon_wdata = '0;
    endtask

    // Monitor: samples the ports after each falling edge and checks queued items
    always @(negedge osc_clk) begin
        int act;
        #2;
        if (cpu_clk_en) hi_cnt++;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            case (it.field)
                F_RST:   act = int'(core_rst);
                F_OSC:   act = int'(osc_run);
                F_PER:   act = int'(per_clk_en | per_last);
                F_CPU:   act = int'(cpu_clk_en | cpu_last);
                F_BITS:  act = int'(pcon_bits);
                default: act = hi_cnt;
            endcase
            n_cmp++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s field %0d: actual %0d expected %0d", it.req, it.field, act, it.exp);
            end
        end
        cpu_last = cpu_clk_en;
        per_last = per_clk_en;
    end

    initial begin
        // R3: power-on reset holds the core in reset
        tick(3);
        expect_f("R3", F_RST, 1);
        tick(1);
        por_n = 1'b1;
        tick(5);
        expect_f("R3", F_RST, 0);
        expect_f("R4", F_OSC, 1);
        expect_f("R4", F_CPU, 1);
        expect_f("R4", F_PER, 1);
        expect_f("R5", F_BITS, 0);
        // R4: enables run at half rate
        tick(1);
        hi_cnt = 0;
        tick(9);
        expect_f("R4", F_CNT, 5);
        // R2: short pulse is dropped
        tick(1);
        rst_pin = 1'b1;
        tick(20);
        expect_f("R2", F_RST, 0);
        rst_pin = 1'b0;
        tick(5);
        expect_f("R2", F_RST, 0);
        // R1: exact qualification edge
        rst_pin = 1'b1;
        tick(24);
        expect_f("R1", F_RST, 0);
        tick(3);
        expect_f("R1", F_RST, 1);
        rst_pin = 1'b0;
        tick(4);
        expect_f("R3", F_RST, 0);
        // R5: idle entry
        pwrite(8'h01);
        tick(4);
        expect_f("R5", F_CPU, 0);
        expect_f("R5", F_PER, 1);
        expect_f("R5", F_OSC, 1);
        expect_f("R5", F_BITS, 1);
        // R11: a write in idle is ignored
        pwrite(8'h02);
        tick(3);
        expect_f("R11", F_BITS, 1);
        expect_f("R11", F_OSC, 1);
        // R6: interrupt wakes from idle
        irq_req = 4'b0100;
        tick(1);
        irq_req = '0;
        tick(4);
        expect_f("R6", F_CPU, 1);
        expect_f("R6", F_BITS, 0);
        // R8: both bits set, power-down wins
        pwrite(8'h03);
        tick(4);
        expect_f("R8", F_OSC, 0);
        expect_f("R8", F_PER, 0);
        expect_f("R8", F_CPU, 0);
        expect_f("R8", F_BITS, 3);
        // R9: interrupts ignored in power-down
        irq_req = 4'b1111;
        tick(3);
        irq_req = '0;
        tick(4);
        expect_f("R9", F_OSC, 0);
        expect_f("R9", F_BITS, 3);
        // R10: reset restarts the oscillator, then exits power-down
        rst_pin = 1'b1;
        tick(3);
        expect_f("R10", F_OSC, 1);
        tick(27);
        expect_f("R10", F_RST, 1);
        expect_f("R10", F_BITS, 0);
        rst_pin = 1'b0;
        tick(5);
        expect_f("R10", F_CPU, 1);
        // R7: reset ends idle
        pwrite(8'h01);
        tick(3);
        expect_f("R7", F_BITS, 1);
        rst_pin = 1'b1;
        tick(30);
        expect_f("R7", F_RST, 1);
        expect_f("R7", F_BITS, 0);
        // R11: writes ignored while in reset
        pwrite(8'h01);
        tick(3);
        expect_f("R11", F_BITS, 0);
        expect_f("R11", F_CPU, 1);
        rst_pin = 1'b0;
        tick(5);
        expect_f("R7", F_CPU, 1);
        expect_f("R7", F_RST, 0);
        tick(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule